// File: doc/BRIEF.md
# Colour Pattern Byte Fetcher for 24-bit Blits

During a bit-block transfer at three bytes per pixel, each destination pixel needs one pixel from an 8x8 colour pattern held in memory. This block takes a fetch request carrying the pattern base address, the low destination-address bits that set the horizontal phase, a vertical alignment value and the current blit x and y. It computes where the wanted pattern pixel lives and issues three byte reads to a simple memory port. It then returns the assembled 24-bit pixel on an output stream.

Pattern rows are padded in memory to a 32-byte pitch, although a row of eight 3-byte pixels fills only 24 bytes. The row is picked by the alignment value plus y, and the column by the destination phase plus x. Both wrap within the 8x8 tile.

All three interfaces use valid/ready. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. A read leaves only in a cycle where `mem_rd_valid` and `mem_rd_ready` are both high. While the read port stalls, the offered address holds steady. Read data returns in issue order as one-cycle `mem_rsp_valid` pulses. The pixel output holds its data until `pix_ready` takes it, and only then does the block accept the next request.

Top module: `pat_fetch_agen`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_rd_valid` and `pix_valid` are both 0.
- R2: The row index is (`req_valign` + low 3 bits of `req_y`) mod 8. Its byte offset is 32 times the row index.
- R3: The column index is (`req_dst_lo` + low 3 bits of `req_x`) mod 8. Its byte offset is 3 times the column index. Higher bits of x and y have no effect.
- R4: Each fetch issues reads at start, start+1 and start+2, in that order. The start address is base + row offset + column offset. A read that is offered but not taken keeps its address unchanged in the next cycle.
- R5: Each fetch issues exactly three reads, at most one per cycle.
- R6: The pixel is little-endian. The first returned byte forms bits 7:0, the second bits 15:8 and the third bits 23:16.
- R7: `pix_valid` rises only after the third read response. While `pix_ready` is low, `pix_valid` and `pix_data` stay unchanged.
- R8: `req_ready` is low from the accepting cycle until the pixel is taken. A `req_valid` seen during that time is ignored and does not change the pixel in flight.
- R9: Address sums wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_base | input | AW (16) | Pattern base byte address |
| req_dst_lo | input | 3 | Low destination-address bits (horizontal phase) |
| req_valign | input | 3 | Vertical pattern alignment |
| req_x | input | XW (12) | Current blit x |
| req_y | input | YW (12) | Current blit y |
| mem_rd_valid | output | 1 | Byte read offered |
| mem_rd_ready | input | 1 | Memory accepts read |
| mem_rd_addr | output | AW (16) | Byte read address |
| mem_rsp_valid | input | 1 | Read data returned (in order) |
| mem_rsp_data | input | 8 | Returned byte |
| pix_valid | output | 1 | Assembled pixel available |
| pix_ready | input | 1 | Consumer takes pixel |
| pix_data | output | 24 | Assembled pattern pixel |

## Verification
The assertions assume that the memory returns exactly one in-order response for each accepted read, and never returns one while no read is outstanding. The bench memory model responds one cycle after each accepted read and cannot produce stray data. The bench sweeps every combination of alignment, y phase, destination phase and x phase, and randomises the upper coordinate bits. It stalls the read port on alternate cycles in some fetches, holds the output back for zero to two cycles, and drives conflicting requests while a fetch is in progress.

// File: rtl/pat_fetch_pkg.sv
package pat_fetch_pkg;
  localparam int unsigned TILE_DIM   = 8;
  localparam int unsigned IDX_W      = $clog2(TILE_DIM);
  localparam int unsigned PIX_BYTES  = 3;
  localparam int unsigned ROW_PITCH  = 32;
  localparam int unsigned PITCH_SH   = $clog2(ROW_PITCH);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/pat_addr_calc.sv
module pat_addr_calc
  import pat_fetch_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned XW = 12,
  parameter int unsigned YW = 12
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] dst_lo,
  input  logic [IDX_W-1:0] valign,
  input  logic [XW-1:0]    x,
  input  logic [YW-1:0]    y,
  output logic [AW-1:0]    start_addr
);
  logic [IDX_W-1:0] row_idx;
  logic [IDX_W-1:0] col_idx;
  logic [AW-1:0]    row_off;
  logic [AW-1:0]    col_off;

  // indices wrap inside the tile by truncation
  assign row_idx = valign + y[IDX_W-1:0];
  assign col_idx = dst_lo + x[IDX_W-1:0];

  assign row_off = AW'(row_idx) << PITCH_SH;
  assign col_off = AW'(col_idx) * AW'(PIX_BYTES);

  assign start_addr = base + row_off + col_off;
endmodule

// File: rtl/pat_byte_pack.sv
module pat_byte_pack #(
  parameter int unsigned NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          last,
  output logic [8*NB-1:0] pixel
);
  localparam int unsigned CW = (NB > 1) ? $clog2(NB) : 1;

  logic [CW-1:0] lane;

  assign last = in_valid && (lane == CW'(NB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lane <= '0;
    end else if (in_valid) begin
      lane <= last ? '0 : lane + 1'b1;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pixel[8*i +: 8] <= '0;
      end else if (in_valid && lane == CW'(i)) begin
        pixel[8*i +: 8] <= in_data;
      end
    end
  end
endmodule

// File: rtl/pat_fetch_ctrl.sv
module pat_fetch_ctrl
  import pat_fetch_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] start_addr,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic          rsp_take,
  input  logic          rsp_last,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic          accept
);
  localparam int unsigned CW = $clog2(NB + 1);

  fetch_state_e  state;
  logic [CW-1:0] iss_cnt;
  logic [AW-1:0] base_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_valid  = (state == ST_FETCH) && (iss_cnt != CW'(NB));
  assign rd_addr   = base_q + AW'(iss_cnt);
  assign rsp_take  = (state == ST_FETCH);
  assign pix_valid = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      iss_cnt <= '0;
      base_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            base_q  <= start_addr;
            iss_cnt <= '0;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (rd_valid && rd_ready) iss_cnt <= iss_cnt + 1'b1;
          if (rsp_last) state <= ST_DONE;
        end
        ST_DONE: begin
          if (pix_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pat_fetch_agen.sv
module pat_fetch_agen
  import pat_fetch_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned XW = 12,
  parameter int unsigned YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_base,
  input  logic [2:0]    req_dst_lo,
  input  logic [2:0]    req_valign,
  input  logic [XW-1:0] req_x,
  input  logic [YW-1:0] req_y,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [7:0]    mem_rsp_data,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [23:0]   pix_data
);
  logic [AW-1:0] start_addr;
  logic          rsp_take;
  logic          rsp_last;
  logic          accept;

  pat_addr_calc #(.AW(AW), .XW(XW), .YW(YW)) u_addr (
    .base       (req_base),
    .dst_lo     (req_dst_lo),
    .valign     (req_valign),
    .x          (req_x),
    .y          (req_y),
    .start_addr (start_addr)
  );

  pat_fetch_ctrl #(.AW(AW), .NB(PIX_BYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .start_addr (start_addr),
    .rd_valid   (mem_rd_valid),
    .rd_ready   (mem_rd_ready),
    .rd_addr    (mem_rd_addr),
    .rsp_take   (rsp_take),
    .rsp_last   (rsp_last),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .accept     (accept)
  );

  pat_byte_pack #(.NB(PIX_BYTES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .in_valid (mem_rsp_valid && rsp_take),
    .in_data  (mem_rsp_data),
    .last     (rsp_last),
    .pixel    (pix_data)
  );
endmodule

// File: rtl/pat_fetch_agen_chk.sv
module pat_fetch_agen_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          mem_rsp_valid,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [23:0]   pix_data
);
  logic [2:0]    n_iss;
  logic [AW-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_iss     <= '0;
      prev_addr <= '0;
    end else if (req_valid && req_ready) begin
      n_iss <= '0;
    end else if (mem_rd_valid && mem_rd_ready) begin
      n_iss     <= n_iss + 1'b1;
      prev_addr <= mem_rd_addr;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_valid && !pix_valid));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && n_iss != 3'd0) |-> (mem_rd_addr == prev_addr + AW'(1)));

  p_three_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (n_iss < 3'd3));

  p_pix_after_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (n_iss == 3'd3));

  p_pix_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> $past(mem_rsp_valid));

  p_pix_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind pat_fetch_agen pat_fetch_agen_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .pix_valid     (pix_valid),
  .pix_ready     (pix_ready),
  .pix_data      (pix_data)
);

// File: tb/test_pat_fetch_agen.sv
`timescale 1ns/1ps
module test_pat_fetch_agen;
  localparam int AW = 16;
  localparam int XW = 12;
  localparam int YW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_base = '0;
  logic [2:0]    req_dst_lo = '0;
  logic [2:0]    req_valign = '0;
  logic [XW-1:0] req_x = '0;
  logic [YW-1:0] req_y = '0;
  logic          mem_rd_valid;
  logic          mem_rd_ready = 1'b1;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [7:0]    mem_rsp_data = '0;
  logic          pix_valid;
  logic          pix_ready = 1'b0;
  logic [23:0]   pix_data;

  int errors = 0;
  int checks = 0;
  bit stall_en = 1'b0;
  int n_iss = 0;
  logic [AW-1:0] got_addr [0:7];

  always #4 clk = ~clk;

  pat_fetch_agen #(.AW(AW), .XW(XW), .YW(YW)) i_pat_fetch_agen (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_dst_lo(req_dst_lo), .req_valign(req_valign),
    .req_x(req_x), .req_y(req_y),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: one-cycle latency, in order
  always @(posedge clk) begin
    if (mem_rd_valid && mem_rd_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_byte(mem_rd_addr);
      if (n_iss < 8) got_addr[n_iss] <= mem_rd_addr;
      n_iss <= n_iss + 1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  always @(negedge clk) mem_rd_ready <= stall_en ? ~mem_rd_ready : 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [AW-1:0] base, input logic [2:0] dlo,
                       input logic [2:0] va, input logic [XW-1:0] x,
                       input logic [YW-1:0] y, input bit stall, input int hold);
    logic [2:0]    row;
    logic [2:0]    col;
    logic [AW-1:0] st;
    logic [23:0]   exp_pix;
    logic [23:0]   first;
    bit            seen;
    row = va + y[2:0];
    col = dlo + x[2:0];
    st  = base + AW'(32) * AW'(row) + AW'(3) * AW'(col);
    exp_pix = {mem_byte(st + AW'(2)), mem_byte(st + AW'(1)), mem_byte(st)};
    stall_en = stall;
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready before request", req_ready, 1);
    req_base = base; req_dst_lo = dlo; req_valign = va; req_x = x; req_y = y;
    req_valid = 1'b1;
    n_iss = 0;
    @(negedge clk);
    // conflicting request while busy (R8)
    req_base = ~base; req_dst_lo = ~dlo; req_valign = ~va; req_x = ~x; req_y = ~y;
    check(req_ready == 1'b0, "R8", "ready while busy", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      if (pix_valid) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen, "R7", "pixel appears", seen, 1);
    check(n_iss == 3, "R5", "read count", n_iss, 3);
    for (int k = 0; k < 3; k++)
      check(got_addr[k] == st + AW'(k), "R4", "read address", got_addr[k], st + AW'(k));
    check(pix_data == exp_pix, "R6", "pixel data", pix_data, exp_pix);
    first = pix_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(pix_valid && pix_data == first, "R7", "pixel held", pix_data, first);
    end
    pix_ready = 1'b1;
    @(negedge clk);
    pix_ready = 1'b0;
    check(!pix_valid && req_ready, "R8", "idle after take", {pix_valid, req_ready}, 2'b01);
    stall_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    check(mem_rd_valid == 1'b0, "R1", "reset mem_rd_valid", mem_rd_valid, 0);
    check(pix_valid == 1'b0, "R1", "reset pix_valid", pix_valid, 0);

    // R2 / R3: full sweep of row and column phases, upper bits varied
    for (int va = 0; va < 8; va++)
      for (int yi = 0; yi < 8; yi++)
        for (int dl = 0; dl < 8; dl++)
          for (int xi = 0; xi < 8; xi++) begin
            logic [XW-1:0] xv;
            logic [YW-1:0] yv;
            logic [AW-1:0] bv;
            xv = XW'($urandom) & ~XW'(7) | XW'(xi);
            yv = YW'($urandom) & ~YW'(7) | YW'(yi);
            bv = AW'(16'h1000 + va * 16'h0111 + yi * 16'h0040);
            fetch(bv, 3'(dl), 3'(va), xv, yv, ((xi ^ yi) & 1) == 1, dl % 3);
          end

    // R9: address wrap at top of space
    fetch(16'hFFF0, 3'd7, 3'd7, 12'd0, 12'd0, 1'b0, 0);
    fetch(16'hFF00, 3'd3, 3'd4, 12'hFFF, 12'hFFB, 1'b1, 2);
    fetch(16'hFFFF, 3'd0, 3'd0, 12'd0, 12'd0, 1'b0, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule